// File: doc/BRIEF.md
# Sideband Address Request Decoder

This block sits on the memory-controller side of a graphics port. It takes the byte stream that the requesting device drives on an 8-bit one-way sideband address bus and rebuilds complete memory requests from it. Each request carries a 4-bit command, a 36-bit byte address and a 3-bit length code. The device sends the bytes in pairs, most significant byte first, and each 16-bit word has one of three kinds. A low word carries address bits 14:3 and the length code. A command word carries the command and address bits 22:15. An upper word carries address bits 35:23.

Command and upper words only update registers that keep their value between requests. A low word completes a request. The decoder fills in the fields that were not sent from those registers, so a request whose upper bits match the previous one costs only two bytes, and a full request costs six. Because transfers are 8-byte aligned, the three least significant address bits are never sent and are zero in the output.

Completed requests wait in a one-entry output slot with a valid/ready handshake. If a new request completes while the slot is still held, the new request is dropped and an error pulse is raised.

Top module: `sideband_req_decoder`

## Requirements
- R1: After reset, req_valid and ovf_err are 0, the byte pairing is at a word boundary, and the kept command, address bits 22:15 and address bits 35:23 are all zero.
- R2: A byte of 8'hFF that arrives where a word would start is discarded. An 8'hFF byte in the second position of a word is data.
- R3: A word with bit 15 = 0 is a low word. One cycle after its second byte, req_valid is 1, req_addr[14:3] = word[14:3], req_addr[2:0] = 0 and req_len = word[2:0].
- R4: A word with bits 15:12 = 4'b1000 is a command word. It sets the kept command to word[11:8] and kept address bits 22:15 to word[7:0], and it produces no request.
- R5: A word with bits 15:13 = 3'b110 is an upper word. It sets kept address bits 35:23 to word[12:0] and produces no request.
- R6: A request takes req_cmd and req_addr[35:15] from the kept registers. A low word leaves those registers unchanged, so the next low word reuses them.
- R7: A word with any other prefix (bits 15:12 = 4'b1001, 4'b1010 or 4'b1011, or bits 15:13 = 3'b111) is reserved. It produces no request and changes no kept register.
- R8: While req_valid = 1 and req_ready = 0, req_valid stays 1 and req_cmd, req_addr and req_len stay unchanged.
- R9: If a low word completes while req_valid = 1 and req_ready = 0, ovf_err is 1 for exactly the next cycle, the new request is dropped and the held request is unchanged.
- R10: If a low word completes in the same cycle that the held request is accepted (req_ready = 1), the new request is loaded into the slot and ovf_err stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_byte | input | 8 | Sideband byte, one per cycle |
| req_ready | input | 1 | Consumer accepts the held request |
| req_valid | output | 1 | Output slot holds a request |
| req_cmd | output | 4 | Request command |
| req_addr | output | 36 | Request byte address, bits 2:0 zero |
| req_len | output | 3 | Request length code |
| ovf_err | output | 1 | One-cycle pulse: a request was dropped |

## Verification
A request is due exactly one clock after the edge that samples the second byte of its low word. The overflow pulse is due on the same edge and lasts one cycle. The bench drives each byte on a falling edge and samples on the falling edge that follows the completing edge, so every result is read half a cycle after it settles. Command, upper and reserved words are checked at that same point: req_valid must still be 0, and a later low word must show whether the kept fields changed.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int ADDR_W  = 36;
  localparam int CMD_W   = 4;
  localparam int LEN_W   = 3;
  localparam int LOWF_W  = 12;                  // address bits 14:3
  localparam int MID_W   = 8;                   // address bits 22:15
  localparam int UP_W    = ADDR_W - LOWF_W - MID_W - LEN_W; // bits 35:23
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

  typedef enum logic [1:0] {
    WK_LOW   = 2'd0,
    WK_CMD   = 2'd1,
    WK_UPPER = 2'd2,
    WK_RSVD  = 2'd3
  } word_kind_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } req_t;

  function automatic word_kind_e classify(input logic [WORD_W-1:0] w);
    if (!w[15])                 return WK_LOW;
    else if (w[15:12] == 4'b1000) return WK_CMD;
    else if (w[15:13] == 3'b110)  return WK_UPPER;
    else                          return WK_RSVD;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(
      input logic [UP_W-1:0]   up,
      input logic [MID_W-1:0]  mid,
      input logic [WORD_W-1:0] w);
    return {up, mid, w[LOWF_W+LEN_W-1:LEN_W], {LEN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/sbd_byte_pair.sv
module sbd_byte_pair
  import sbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_stb,
  output logic [WORD_W-1:0] word
);
  logic              have_hi;
  logic [BYTE_W-1:0] hi_q;
  logic              idle_drop;

  assign idle_drop = !have_hi && (byte_in == IDLE_BYTE);
  assign word_stb  = have_hi;
  assign word      = {hi_q, byte_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_hi <= 1'b0;
      hi_q    <= '0;
    end else if (have_hi) begin
      have_hi <= 1'b0;
    end else if (!idle_drop) begin
      have_hi <= 1'b1;
      hi_q    <= byte_in;
    end
  end

  AST_IDLE_STAYS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_drop |=> !word_stb); // R2
endmodule

// File: rtl/sbd_sticky.sv
module sbd_sticky
  import sbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  word_kind_e        kind,
  input  logic [WORD_W-1:0] word,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [MID_W-1:0]  mid_q,
  output logic [UP_W-1:0]   up_q
);
  logic ld_cmd, ld_up;
  assign ld_cmd = word_stb && (kind == WK_CMD);
  assign ld_up  = word_stb && (kind == WK_UPPER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      mid_q <= '0;
      up_q  <= '0;
    end else begin
      if (ld_cmd) begin
        cmd_q <= word[11:8];
        mid_q <= word[MID_W-1:0];
      end
      if (ld_up) up_q <= word[UP_W-1:0];
    end
  end

  AST_LOW_KEEPS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && kind == WK_LOW) |=> ($stable(up_q) && $stable(mid_q) && $stable(cmd_q))); // R6
  AST_RSVD_KEEPS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && kind == WK_RSVD) |=> ($stable(up_q) && $stable(mid_q) && $stable(cmd_q))); // R7
endmodule

// File: rtl/sbd_out_slot.sv
module sbd_out_slot
  import sbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic new_stb,
  input  req_t new_req,
  input  logic ready,
  output logic valid,
  output req_t req_q,
  output logic ovf_q
);
  logic blocked;
  assign blocked = valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      req_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (new_stb) begin
        if (blocked) begin
          ovf_q <= 1'b1;
        end else begin
          valid <= 1'b1;
          req_q <= new_req;
        end
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(req_q))); // R8
  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(valid && !ready)); // R9
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R9
endmodule

// File: rtl/sideband_req_decoder.sv
module sideband_req_decoder
  import sbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sb_byte,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [35:0]       req_addr,
  output logic [2:0]        req_len,
  output logic              ovf_err
);
  logic              word_stb;
  logic [WORD_W-1:0] word;
  word_kind_e        kind;
  logic              low_stb;
  logic [CMD_W-1:0]  cmd_q;
  logic [MID_W-1:0]  mid_q;
  logic [UP_W-1:0]   up_q;
  req_t              new_req;
  req_t              slot_req;

  sbd_byte_pair u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_in  (sb_byte),
    .word_stb (word_stb),
    .word     (word)
  );

  assign kind    = classify(word);
  assign low_stb = word_stb && (kind == WK_LOW);

  sbd_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .kind     (kind),
    .word     (word),
    .cmd_q    (cmd_q),
    .mid_q    (mid_q),
    .up_q     (up_q)
  );

  always_comb begin
    new_req.cmd  = cmd_q;
    new_req.addr = join_addr(up_q, mid_q, word);
    new_req.len  = word[LEN_W-1:0];
  end

  sbd_out_slot u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .new_stb (low_stb),
    .new_req (new_req),
    .ready   (req_ready),
    .valid   (req_valid),
    .req_q   (slot_req),
    .ovf_q   (ovf_err)
  );

  assign req_cmd  = slot_req.cmd;
  assign req_addr = slot_req.addr;
  assign req_len  = slot_req.len;

  AST_REQ_NEEDS_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(low_stb)); // R3
  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[2:0] == 3'b000)); // R3
  AST_NON_LOW_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && kind != WK_LOW && !req_valid) |=> !req_valid); // R4
endmodule

// File: tb/sideband_req_decoder_bench.sv
module sideband_req_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sb_byte = 8'hFF;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [3:0]  req_cmd;
  logic [35:0] req_addr;
  logic [2:0]  req_len;
  logic        ovf_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of kept fields
  logic [12:0] m_up  = '0;
  logic [7:0]  m_mid = '0;
  logic [3:0]  m_cmd = '0;

  always #4 clk = ~clk; // 125 MHz

  sideband_req_decoder u_sideband_req_decoder (
    .clk(clk), .rst_n(rst_n), .sb_byte(sb_byte), .req_ready(req_ready),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] expect_addr(input logic [15:0] w);
    logic [35:0] a;
    a = (36'(m_up) << 23) | (36'(m_mid) << 15) | 36'(w & 16'h7FF8);
    return a;
  endfunction

  task automatic send_word(input logic [15:0] w);
    @(negedge clk) sb_byte = w[15:8];
    @(negedge clk) sb_byte = w[7:0];
    @(negedge clk) sb_byte = 8'hFF;
  endtask

  task automatic check_req(input string tag, input logic [15:0] w);
    chk(req_valid === 1'b1, {tag, " valid"}, 64'(req_valid), 64'd1);
    chk(req_addr === expect_addr(w), {tag, " addr"}, 64'(req_addr), 64'(expect_addr(w)));
    chk(req_len === w[2:0], {tag, " len"}, 64'(req_len), 64'(w[2:0]));
    chk(req_cmd === m_cmd, {tag, " cmd"}, 64'(req_cmd), 64'(m_cmd));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0, "R1 valid after reset", 64'(req_valid), 64'd0);
    chk(ovf_err === 1'b0, "R1 ovf after reset", 64'(ovf_err), 64'd0);
    send_word(16'h1235);
    check_req("R1 zero sticky", 16'h1235);
  endtask

  task automatic t_low_word;
    send_word(16'h7FFE);
    check_req("R3 low word", 16'h7FFE);
    send_word(16'h0009);
    check_req("R3 low word small", 16'h0009);
  endtask

  task automatic t_cmd_upper;
    send_word(16'hD5A5); m_up = 13'h15A5;
    chk(req_valid === 1'b0, "R5 upper no req", 64'(req_valid), 64'd0);
    send_word(16'h8A3C); m_cmd = 4'hA; m_mid = 8'h3C;
    chk(req_valid === 1'b0, "R4 cmd no req", 64'(req_valid), 64'd0);
    send_word(16'h4442);
    check_req("R4 R5 full request", 16'h4442);
  endtask

  task automatic t_sticky_reuse;
    send_word(16'h0F13);
    check_req("R6 reuse kept fields", 16'h0F13);
  endtask

  task automatic t_idle;
    @(negedge clk) sb_byte = 8'hFF;
    @(negedge clk) sb_byte = 8'hFF;
    chk(req_valid === 1'b0, "R2 idle no req", 64'(req_valid), 64'd0);
    send_word(16'h12FF);
    check_req("R2 FF as low byte", 16'h12FF);
  endtask

  task automatic t_reserved;
    send_word(16'h9ABC);
    chk(req_valid === 1'b0, "R7 rsvd 1001 no req", 64'(req_valid), 64'd0);
    send_word(16'hE123);
    chk(req_valid === 1'b0, "R7 rsvd 111 no req", 64'(req_valid), 64'd0);
    send_word(16'hB001);
    send_word(16'h0208);
    check_req("R7 kept fields unchanged", 16'h0208);
  endtask

  task automatic t_hold_overflow;
    logic [35:0] held;
    @(negedge clk) req_ready = 1'b0;
    send_word(16'h3333);
    check_req("R8 held request", 16'h3333);
    held = req_addr;
    repeat (3) begin
      @(negedge clk);
      chk(req_valid === 1'b1 && req_addr === held, "R8 stable while stalled", 64'(req_addr), 64'(held));
    end
    send_word(16'h5555);
    chk(ovf_err === 1'b1, "R9 overflow pulse", 64'(ovf_err), 64'd1);
    chk(req_addr === held && req_len === 3'd3, "R9 held kept", 64'(req_addr), 64'(held));
    @(negedge clk);
    chk(ovf_err === 1'b0, "R9 pulse one cycle", 64'(ovf_err), 64'd0);
    req_ready = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0, "R8 released after ready", 64'(req_valid), 64'd0);
  endtask

  task automatic t_simultaneous;
    @(negedge clk) req_ready = 1'b0;
    send_word(16'h1110);
    check_req("R10 first held", 16'h1110);
    @(negedge clk) sb_byte = 8'h26;
    @(negedge clk) begin sb_byte = 8'h6E; req_ready = 1'b1; end
    @(negedge clk) sb_byte = 8'hFF;
    check_req("R10 new loaded", 16'h266E);
    chk(ovf_err === 1'b0, "R10 no overflow", 64'(ovf_err), 64'd0);
    @(negedge clk);
    chk(req_valid === 1'b0, "R10 drained", 64'(req_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_word();
    t_cmd_upper();
    t_sticky_reuse();
    t_idle();
    t_reserved();
    t_hold_overflow();
    t_simultaneous();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule